// File: doc/BRIEF.md
# Binary Tower Field Multiplier

This block multiplies two elements of a binary tower field. It is pipelined and accepts a new operand pair on every clock. The tower starts at GF(2), where an element is one bit. Each higher level is a quadratic extension of the level below, so an element at level k is 2^k bits wide. Its low half holds the coefficient a0 and its high half holds a1, giving a = a0 + a1·x_k. The generators obey x_k² = x_k·x_{k-1} + 1, with x_0 = 1. Addition at every level is bitwise XOR.

A level input is supplied with each operand pair and selects the field, from GF(2) up to the 128-bit field at level 7. For a level below the top, only the low 2^k bits of each operand are meaningful. Each element of a lower level is also an element of the top field, with its upper bits zero. For this reason one Karatsuba datapath serves every level. The operands are masked on entry, and the upper product bits then come out zero without any extra logic.

The datapath splits into three level-6 subproducts formed by recursive Karatsuba, with single-bit AND gates at the leaves. These are followed by a recombination stage that needs one multiplication by a generator. The latency is fixed at three cycles for every level.

Top module: `btf_mul`

## Requirements
- R1: For level 7, out_prod equals a·b in the tower field. Bit i of an element is the coefficient of the monomial that is the product of x_t over every t for which bit t-1 of i is set. The generators satisfy x_k² = x_k·x_{k-1} + 1 with x_0 = 1. For example, at level 1, 2·2 = 3, and at level 2, 4·4 = 9.
- R2: For in_level k < 7, operand bits 2^k and above have no effect on out_prod.
- R3: For in_level k < 7, out_prod bits 2^k and above are zero, and the low 2^k bits equal the level-k field product.
- R4: At level 0, out_prod is {127'b0, in_a[0] & in_b[0]}.
- R5: out_valid equals in_valid delayed by exactly three clock cycles. out_prod carries the result of the operands presented three cycles earlier.
- R6: Operand pairs with different levels may be presented on consecutive cycles, and each result is correct for its own level.
- R7: The element 1 (value 1) is a multiplicative identity at every level.
- R8: The product is commutative at every level.
- R9: At every level, a·(b ⊕ c) = a·b ⊕ a·c.
- R10: While rst is high, and on the first cycle after it is released, out_valid and out_prod are zero.
- R11: When either operand is zero within the selected level, the product is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand pair is valid |
| in_a | input | 128 | First operand |
| in_b | input | 128 | Second operand |
| in_level | input | 3 | Tower level k; the field has 2^k-bit elements |
| out_valid | output | 1 | Product is valid |
| out_prod | output | 128 | Product, zero above bit 2^k-1 |

## Verification
A wrong Karatsuba leaf, a wrong generator multiply or a bad masking step gives a wrong out_prod exactly three cycles after the faulty operands enter. Such a fault usually shows only for certain levels or bit patterns, so the bench compares every cycle against a shift-and-add reference that has none of the recursive structure. Errors in the generator rule tend to surface first at the higher levels. Masking faults show as nonzero upper bits at lower levels. A broken valid pipeline shows as out_valid misaligned with the expected queue on the first transaction after an idle gap.

// File: rtl/btf_pkg.sv
package btf_pkg;
  // Highest tower level supported by default (2^7 = 128-bit elements).
  localparam int unsigned MAX_LVL = 7;
  // Register stages from operand capture to product output.
  localparam int unsigned PIPE_STAGES = 3;

  // Element width at a given tower level.
  function automatic int unsigned elem_w(input int unsigned lvl);
    return 1 << lvl;
  endfunction
endpackage

// File: rtl/tower_mulx.sv
// Multiplies a level-M element by the generator x_M (combinational).
// For c = c0 + c1*x_M:  c*x_M = c1 + (c0 + c1*x_{M-1})*x_M, with x_0 = 1.
module tower_mulx #(
  parameter int unsigned M = 1
) (
  input  logic [(1<<M)-1:0] c,
  output logic [(1<<M)-1:0] y
);
  generate
    if (M == 0) begin : g_leaf
      assign y = c;
    end else begin : g_rec
      localparam int unsigned H = (1 << M) / 2;
      logic [H-1:0] hi_x;
      tower_mulx #(.M(M-1)) u_sub (
        .c (c[2*H-1:H]),
        .y (hi_x)
      );
      assign y = {c[H-1:0] ^ hi_x, c[2*H-1:H]};
    end
  endgenerate
endmodule

// File: rtl/tower_kmul.sv
// Combinational level-L tower multiply by recursive Karatsuba.
module tower_kmul #(
  parameter int unsigned L = 1
) (
  input  logic [(1<<L)-1:0] a,
  input  logic [(1<<L)-1:0] b,
  output logic [(1<<L)-1:0] y
);
  generate
    if (L == 0) begin : g_leaf
      assign y = a & b;
    end else begin : g_rec
      localparam int unsigned H = (1 << L) / 2;

      function automatic logic [2*H-1:0] join_halves(
        input logic [H-1:0] q0,
        input logic [H-1:0] q1,
        input logic [H-1:0] qm,
        input logic [H-1:0] q1x
      );
        return {qm ^ q0 ^ q1 ^ q1x, q0 ^ q1};
      endfunction

      logic [H-1:0] p_lo, p_hi, p_mid, p_hi_x;
      logic [H-1:0] a_sum, b_sum;
      assign a_sum = a[H-1:0] ^ a[2*H-1:H];
      assign b_sum = b[H-1:0] ^ b[2*H-1:H];

      tower_kmul #(.L(L-1)) u_lo  (.a(a[H-1:0]),   .b(b[H-1:0]),   .y(p_lo));
      tower_kmul #(.L(L-1)) u_hi  (.a(a[2*H-1:H]), .b(b[2*H-1:H]), .y(p_hi));
      tower_kmul #(.L(L-1)) u_mid (.a(a_sum),      .b(b_sum),      .y(p_mid));
      tower_mulx #(.M(L-1)) u_gx  (.c(p_hi),       .y(p_hi_x));

      assign y = join_halves(p_lo, p_hi, p_mid, p_hi_x);
    end
  endgenerate
endmodule

// File: rtl/btf_mul.sv
// Pipelined binary tower field multiplier, run-time level select.
// Stage 1: capture masked operands. Stage 2: three half-size Karatsuba
// subproducts. Stage 3: recombine with one generator multiply.
module btf_mul
  import btf_pkg::*;
#(
  parameter int unsigned TOP_LVL = MAX_LVL
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           in_valid,
  input  logic [(1<<TOP_LVL)-1:0]        in_a,
  input  logic [(1<<TOP_LVL)-1:0]        in_b,
  input  logic [$clog2(TOP_LVL+1)-1:0]   in_level,
  output logic                           out_valid,
  output logic [(1<<TOP_LVL)-1:0]        out_prod
);
  localparam int unsigned W  = elem_w(TOP_LVL);
  localparam int unsigned H  = W / 2;
  localparam int unsigned LW = $clog2(TOP_LVL + 1);

  // Keep bits below 2^lvl; levels at or above the top keep everything.
  function automatic logic [W-1:0] lvl_mask(input logic [LW-1:0] lvl);
    logic [W-1:0] m;
    for (int i = 0; i < int'(W); i++) m[i] = (i < (1 << lvl));
    return m;
  endfunction

  function automatic logic [W-1:0] recombine(
    input logic [H-1:0] q0,
    input logic [H-1:0] q1,
    input logic [H-1:0] qm,
    input logic [H-1:0] q1x
  );
    return {qm ^ q0 ^ q1 ^ q1x, q0 ^ q1};
  endfunction

  // ---- stage 1: masked operand capture
  logic          s1_v;
  logic [W-1:0]  s1_a, s1_b;
  logic [LW-1:0] s1_lvl;
  logic [W-1:0]  op_mask;
  assign op_mask = lvl_mask(in_level);

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v   <= 1'b0;
      s1_a   <= '0;
      s1_b   <= '0;
      s1_lvl <= '0;
    end else begin
      s1_v   <= in_valid;
      s1_a   <= in_a & op_mask;
      s1_b   <= in_b & op_mask;
      s1_lvl <= in_level;
    end
  end

  // ---- stage 2: three half-width subproducts
  logic [H-1:0] sub_lo, sub_hi, sub_mid;
  logic [H-1:0] s1_a_sum, s1_b_sum;
  assign s1_a_sum = s1_a[H-1:0] ^ s1_a[W-1:H];
  assign s1_b_sum = s1_b[H-1:0] ^ s1_b[W-1:H];

  tower_kmul #(.L(TOP_LVL-1)) u_sub_lo  (.a(s1_a[H-1:0]), .b(s1_b[H-1:0]), .y(sub_lo));
  tower_kmul #(.L(TOP_LVL-1)) u_sub_hi  (.a(s1_a[W-1:H]), .b(s1_b[W-1:H]), .y(sub_hi));
  tower_kmul #(.L(TOP_LVL-1)) u_sub_mid (.a(s1_a_sum),    .b(s1_b_sum),    .y(sub_mid));

  logic          s2_v;
  logic [H-1:0]  s2_lo, s2_hi, s2_mid;
  logic [LW-1:0] s2_lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_v   <= 1'b0;
      s2_lo  <= '0;
      s2_hi  <= '0;
      s2_mid <= '0;
      s2_lvl <= '0;
    end else begin
      s2_v   <= s1_v;
      s2_lo  <= sub_lo;
      s2_hi  <= sub_hi;
      s2_mid <= sub_mid;
      s2_lvl <= s1_lvl;
    end
  end

  // ---- stage 3: recombination
  logic [H-1:0]  s2_hi_x;
  logic [LW-1:0] out_lvl;
  tower_mulx #(.M(TOP_LVL-1)) u_gen_x (.c(s2_hi), .y(s2_hi_x));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_prod  <= '0;
      out_lvl   <= '0;
    end else begin
      out_valid <= s2_v;
      out_prod  <= recombine(s2_lo, s2_hi, s2_mid, s2_hi_x);
      out_lvl   <= s2_lvl;
    end
  end
endmodule

// File: rtl/btf_mul_chk.sv
module btf_mul_chk #(
  parameter int unsigned W   = 128,
  parameter int unsigned LW  = 3,
  parameter int unsigned TOP = 7
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          s1_v,
  input logic [W-1:0]  s1_a,
  input logic [W-1:0]  s1_b,
  input logic [LW-1:0] s1_lvl,
  input logic          out_valid,
  input logic [W-1:0]  out_prod,
  input logic [LW-1:0] out_lvl
);
  assert_valid_latency_R5: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ##2 out_valid);

  assert_no_phantom_valid_R5: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ##2 !out_valid);

  assert_operand_masked_R2: assert property (@(posedge clk) disable iff (rst)
    (s1_v && s1_lvl < LW'(TOP)) |->
      ((s1_a >> (1 << s1_lvl)) == '0 && (s1_b >> (1 << s1_lvl)) == '0));

  assert_upper_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_lvl < LW'(TOP)) |-> ((out_prod >> (1 << out_lvl)) == '0));

  assert_level0_and_R4: assert property (@(posedge clk) disable iff (rst)
    (s1_lvl == '0) |=> ##1 (out_prod == {{(W-1){1'b0}}, $past(s1_a[0] & s1_b[0], 2)}));

  assert_one_identity_R7: assert property (@(posedge clk) disable iff (rst)
    (s1_b == W'(1)) |=> ##1 (out_prod == $past(s1_a, 2)));

  assert_zero_absorbs_R11: assert property (@(posedge clk) disable iff (rst)
    (s1_a == '0 || s1_b == '0) |=> ##1 (out_prod == '0));

  assert_reset_clear_R10: assert property (@(posedge clk)
    rst |=> (!out_valid && out_prod == '0));
endmodule

bind btf_mul btf_mul_chk #(.W(W), .LW(LW), .TOP(TOP_LVL)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .s1_v      (s1_v),
  .s1_a      (s1_a),
  .s1_b      (s1_b),
  .s1_lvl    (s1_lvl),
  .out_valid (out_valid),
  .out_prod  (out_prod),
  .out_lvl   (out_lvl)
);

// File: tb/btf_mul_tb.sv
module btf_mul_tb;
  localparam int CLK_P = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [127:0] in_a = '0, in_b = '0;
  logic [2:0]   in_level = '0;
  logic         out_valid;
  logic [127:0] out_prod;

  always #(CLK_P/2) clk = ~clk;

  btf_mul u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .in_level(in_level), .out_valid(out_valid), .out_prod(out_prod)
  );

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic         q_v[$];
  logic [127:0] q_e[$];
  string        q_t[$];
  int           q_id[$];
  logic [127:0] res[int];
  logic [127:0] opa[int];
  logic [2:0]   oplvl[int];

  // ---------------- reference model: shift-and-add over monomials
  function automatic logic [127:0] msk(input logic [2:0] l);
    logic [127:0] m = '0;
    for (int i = 0; i < (1 << l); i++) m[i] = 1'b1;
    return m;
  endfunction

  function automatic logic [127:0] lowpos(input int s);
    logic [127:0] m;
    for (int i = 0; i < 128; i++) m[i] = ((i >> (s - 1)) & 1) == 0;
    return m;
  endfunction

  // multiply every 2^t-bit block by the generator x_t
  function automatic logic [127:0] by_gen(input logic [127:0] v, input int t);
    logic [127:0] u [0:7];
    logic [127:0] r;
    if (t == 0) return v;
    u[t] = v;
    for (int s = t; s >= 1; s--) u[s-1] = (u[s] >> (1 << (s - 1))) & lowpos(s);
    r = u[0];
    for (int s = 1; s <= t; s++) r = u[s-1] | (((u[s] & lowpos(s)) ^ r) << (1 << (s - 1)));
    return r;
  endfunction

  function automatic logic [127:0] ref_mul(input logic [127:0] a, input logic [127:0] b);
    logic [127:0] acc = '0;
    logic [127:0] t;
    for (int j = 0; j < 128; j++) begin
      if (b[j]) begin
        t = a;
        for (int g = 1; g <= 7; g++) if (((j >> (g - 1)) & 1) != 0) t = by_gen(t, g);
        acc ^= t;
      end
    end
    return acc;
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic note(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock: check the result due now, then drive the next pair
  task automatic cyc(input logic v, input logic [127:0] a, input logic [127:0] b,
                     input logic [2:0] l, input string tag, input int id);
    logic ev; logic [127:0] ee; string et; int eid;
    @(negedge clk);
    if (q_v.size() == 3) begin
      ev = q_v.pop_front(); ee = q_e.pop_front(); et = q_t.pop_front(); eid = q_id.pop_front();
      note(out_valid === ev, "R5 out_valid", {127'b0, out_valid}, {127'b0, ev});
      note(out_prod === ee, et, out_prod, ee);
      if (eid >= 0) res[eid] = out_prod;
    end
    in_valid = v; in_a = a; in_b = b; in_level = l;
    q_v.push_back(v);
    q_e.push_back(ref_mul(a & msk(l), b & msk(l)));
    q_t.push_back(tag);
    q_id.push_back(id);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, '0, '0, 3'd0, "R5 idle", -1);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R5 watchdog: actual=unfinished expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int id = 0;
    logic [127:0] a, b, c;
    logic [2:0] l;

    // R10: reset dominates even with valid operands applied
    in_valid = 1'b1; in_a = rnd128(); in_b = rnd128(); in_level = 3'd7;
    repeat (4) @(posedge clk);
    @(negedge clk);
    note(out_valid === 1'b0 && out_prod === '0, "R10 during reset", out_prod, '0);
    rst = 1'b0; in_valid = 1'b0; in_a = '0; in_b = '0; in_level = '0;
    for (int i = 0; i < 3; i++) begin
      q_v.push_back(1'b0); q_e.push_back('0); q_t.push_back("R10 after reset"); q_id.push_back(-1);
    end

    // R1: sanity of the bench model against the generator rule
    note(ref_mul(128'd2, 128'd2) == 128'd3, "R1 model x1^2", ref_mul(128'd2, 128'd2), 128'd3);
    note(ref_mul(128'd4, 128'd4) == 128'd9, "R1 model x2^2", ref_mul(128'd4, 128'd4), 128'd9);

    // R1: generator squares through the DUT
    cyc(1'b1, 128'd2, 128'd2, 3'd1, "R1 x1*x1", -1);
    cyc(1'b1, 128'd4, 128'd4, 3'd2, "R1 x2*x2", -1);
    cyc(1'b1, 128'd1 << 64, 128'd1 << 64, 3'd7, "R1 x7*x7", -1);

    // R4: level 0, all bit pairs, garbage above bit 0
    for (int k = 0; k < 4; k++)
      cyc(1'b1, {rnd128() & ~128'd1} | 128'(k & 1), {rnd128() & ~128'd1} | 128'(k >> 1), 3'd0, "R4 level0", -1);

    // R1: random level-7 products
    for (int k = 0; k < 60; k++) cyc(1'b1, rnd128(), rnd128(), 3'd7, "R1 level7", -1);

    // R2: garbage in the unused operand bits at every lower level
    for (int k = 0; k < 70; k++) cyc(1'b1, rnd128(), rnd128(), 3'(k % 7), "R2 upper ignored", -1);

    // R3: clean operands at lower levels
    for (int k = 0; k < 70; k++) begin
      l = 3'(k % 7);
      cyc(1'b1, rnd128() & msk(l), rnd128() & msk(l), l, "R3 lower level", -1);
    end

    // R6: back-to-back random levels; R5: random valid gaps
    for (int k = 0; k < 300; k++) cyc(1'b1, rnd128(), rnd128(), 3'($urandom % 8), "R6 mixed levels", -1);
    for (int k = 0; k < 200; k++)
      cyc(($urandom % 3) != 0, rnd128(), rnd128(), 3'($urandom % 8), "R5 gapped stream", -1);

    // algebraic properties, collected then compared
    for (int lv = 0; lv < 8; lv++) begin
      for (int k = 0; k < 6; k++) begin
        l = 3'(lv);
        a = rnd128() & msk(l); b = rnd128() & msk(l); c = rnd128() & msk(l);
        opa[id] = a; oplvl[id] = l;
        cyc(1'b1, a, b,     l, "R8 a*b",     id);
        cyc(1'b1, b, a,     l, "R8 b*a",     id + 1);
        cyc(1'b1, a, 128'd1, l, "R7 a*1",    id + 2);
        cyc(1'b1, a, b ^ c, l, "R9 a*(b^c)", id + 3);
        cyc(1'b1, a, c,     l, "R9 a*c",     id + 4);
        cyc(1'b1, a, '0,    l, "R11 a*0",    id + 5);
        id += 6;
      end
    end
    idle(4);

    for (int t = 0; t < id; t += 6) begin
      note(res[t] === res[t+1], "R8 commutative", res[t+1], res[t]);
      note(res[t+2] === opa[t], "R7 identity", res[t+2], opa[t]);
      note(res[t+3] === (res[t] ^ res[t+4]), "R9 distributive", res[t+3], res[t] ^ res[t+4]);
      note(res[t+5] === '0, "R11 zero", res[t+5], '0);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule